// File: doc/BRIEF.md
# Router Link Traffic Counter Agent

This block sits beside a network router and acts as its statistics and configuration agent. It counts the flits that cross each of the router's links, with one saturating counter per link. It acts on read, clear and configuration-load messages that arrive already decoded. Each message carries a target router identifier, a link mask, a broadcast field, a requester tag and a memory address.

A read names one link and gets a single response back one cycle later, tagged for the requester. A clear can zero any subset of counters in one operation. A configuration load fetches a block of words from memory. The fetch starts at the message's base address plus a fixed offset that depends on the local router identifier, and runs over a simple request/response port. While the fetch runs, the agent accepts no new messages. The loaded words appear on the configuration output together, in one step.

Top module: `link_stat_agent`

## Requirements
- R1: Each link i owns a counter of CNT_W bits. The counter rises by exactly one at every clock edge where `flit_pulse[i]` is high.
- R2: A counter at its all-ones value stays there when more flits arrive; it does not wrap to zero.
- R3: A read (opcode 2'b01) with `req_dest` equal to `my_id` and exactly one bit set in `req_mask` selects the link whose index is that bit position. On the next cycle `rsp_valid` is high with `rsp_err` low, `rsp_tag` equal to the request tag, and `rsp_count` equal to the counter value at acceptance, before any increment in that cycle.
- R4: A read whose mask has no bit set, or more than one bit set, still answers one cycle later with its tag, but with `rsp_err` high and `rsp_count` zero.
- R5: A clear (opcode 2'b10) zeroes every counter whose mask bit is set and leaves every other counter untouched.
- R6: When a clear and a flit pulse hit the same counter in the same cycle, the counter ends at zero.
- R7: A clear or a configuration load acts when `req_bcast` is non-zero, or when `req_dest` equals `my_id`. A read acts only when `req_dest` equals `my_id`, whatever `req_bcast` holds. A message that does not target this router has no effect and gets no response. Opcode 2'b00 does nothing.
- R8: A configuration load (opcode 2'b11) fetches CFG_WORDS words in ascending order from address `req_addr + my_id*CFG_STRIDE + k`. Each word is requested with a single-cycle `mem_req`, and only one request is outstanding at a time.
- R9: `cfg_out` holds word k at bits [k*DATA_W +: DATA_W]. It changes only at the edge that takes in the last fetched word, when all words update together. It resets to zero.
- R10: `req_ready` falls the cycle after a configuration load is accepted and stays low until the load completes. Messages presented while it is low are ignored, and the counters keep counting.
- R11: After reset, all counters are zero, `rsp_valid` and `mem_req` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | ID_W | Identifier of the local router |
| req_valid | input | 1 | Message present |
| req_ready | output | 1 | Agent can accept a message |
| req_op | input | 2 | Opcode: 00 none, 01 read, 10 clear, 11 configuration load |
| req_dest | input | ID_W | Target router identifier |
| req_mask | input | N_LINKS | Link mask |
| req_bcast | input | BC_W | Broadcast field; non-zero targets all routers |
| req_tag | input | TAG_W | Requester tag returned with a read |
| req_addr | input | ADDR_W | Configuration base address |
| flit_pulse | input | N_LINKS | One bit per link, high when a flit crossed it this cycle |
| rsp_valid | output | 1 | Read response valid |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_err | output | 1 | Read mask did not select exactly one link |
| rsp_count | output | CNT_W | Counter value returned |
| mem_req | output | 1 | Single-cycle memory word request |
| mem_addr | output | ADDR_W | Address of the requested word |
| mem_rsp_valid | input | 1 | Memory word returned |
| mem_rsp_data | input | DATA_W | Returned word |
| cfg_out | output | CFG_WORDS*DATA_W | Configuration register |

## Verification
A read response is due on the cycle after acceptance. The reference model records the expected response at the accepting rising edge and compares it at the following falling edge, so every response is sampled exactly one register stage later. `req_ready` and `cfg_out` are compared on every falling edge against a model that leaves its busy state, and updates its copy of the configuration, at the same rising edge that delivers the last memory word. Each `mem_addr` is checked during the cycle its `mem_req` is high. Counter contents are observed only through reads, so clears, ignored messages, saturation and the clear-over-increment rule all show up in the value of a later response.

// File: rtl/link_stat_pkg.sv
package link_stat_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_CLEAR = 2'b10,
        OP_CFG   = 2'b11
    } stat_op_e;

    typedef enum logic [1:0] {
        FETCH_IDLE  = 2'b00,
        FETCH_ISSUE = 2'b01,
        FETCH_WAIT  = 2'b10
    } fetch_state_e;

    // Actions decided for one accepted message
    typedef struct packed {
        logic rd;
        logic clr;
        logic cfg;
    } stat_act_t;

    function automatic logic targets_me(input logic wide, input logic match);
        return wide | match;
    endfunction

endpackage

// File: rtl/link_stat_decode.sv
module link_stat_decode
    import link_stat_pkg::*;
#(
    parameter int N_LINKS = 4,
    parameter int ID_W    = 4,
    parameter int BC_W    = 4,
    localparam int SEL_W  = (N_LINKS > 1) ? $clog2(N_LINKS) : 1,
    localparam int ONES_W = $clog2(N_LINKS + 1)
) (
    input  logic               accept,
    input  logic [1:0]         op,
    input  logic [ID_W-1:0]    dest,
    input  logic [ID_W-1:0]    my_id,
    input  logic [BC_W-1:0]    bcast,
    input  logic [N_LINKS-1:0] mask,
    output stat_act_t          act,
    output logic               sel_ok,
    output logic [SEL_W-1:0]   sel_idx
);

    logic              match;
    logic              wide;
    logic [ONES_W-1:0] ones;
    stat_op_e          op_e;

    assign op_e  = stat_op_e'(op);
    assign match = (dest == my_id);
    assign wide  = (bcast != '0);

    always_comb begin
        act     = '0;
        act.rd  = accept && (op_e == OP_READ) && match;
        act.clr = accept && (op_e == OP_CLEAR) && targets_me(wide, match);
        act.cfg = accept && (op_e == OP_CFG) && targets_me(wide, match);
    end

    always_comb begin
        ones    = '0;
        sel_idx = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (mask[i]) begin
                ones    = ones + ONES_W'(1);
                sel_idx = SEL_W'(i);
            end
        end
    end

    assign sel_ok = (ones == ONES_W'(1));

endmodule

// File: rtl/link_stat_counter.sv
module link_stat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (bump && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/link_stat_cfg_fetch.sv
module link_stat_cfg_fetch
    import link_stat_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int CFG_WORDS  = 4,
    parameter int CFG_STRIDE = 16,
    parameter int ID_W       = 4,
    localparam int IDX_W     = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [ADDR_W-1:0]           base,
    input  logic [ID_W-1:0]             my_id,
    output logic                        busy,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_rsp_valid,
    input  logic [DATA_W-1:0]           mem_rsp_data,
    output logic [CFG_WORDS*DATA_W-1:0] cfg_out
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(CFG_WORDS - 1);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(CFG_STRIDE);

    fetch_state_e                          state_q;
    logic [ADDR_W-1:0]                     origin_q;
    logic [IDX_W-1:0]                      idx_q;
    logic [CFG_WORDS-1:0][DATA_W-1:0]      shadow_q;
    logic [CFG_WORDS-1:0][DATA_W-1:0]      shadow_next;
    logic [CFG_WORDS-1:0][DATA_W-1:0]      cfg_q;

    assign busy     = (state_q != FETCH_IDLE);
    assign mem_req  = (state_q == FETCH_ISSUE);
    assign mem_addr = origin_q + ADDR_W'(idx_q);
    assign cfg_out  = cfg_q;

    always_comb begin
        shadow_next        = shadow_q;
        shadow_next[idx_q] = mem_rsp_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FETCH_IDLE;
            origin_q <= '0;
            idx_q    <= '0;
            shadow_q <= '0;
            cfg_q    <= '0;
        end else begin
            unique case (state_q)
                FETCH_IDLE: begin
                    if (start) begin
                        origin_q <= base + ADDR_W'(my_id) * STRIDE_A;
                        idx_q    <= '0;
                        state_q  <= FETCH_ISSUE;
                    end
                end
                FETCH_ISSUE: begin
                    state_q <= FETCH_WAIT;
                end
                FETCH_WAIT: begin
                    if (mem_rsp_valid) begin
                        shadow_q <= shadow_next;
                        if (idx_q == LAST_IDX) begin
                            cfg_q   <= shadow_next;
                            state_q <= FETCH_IDLE;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= FETCH_ISSUE;
                        end
                    end
                end
                default: state_q <= FETCH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/link_stat_agent.sv
module link_stat_agent
    import link_stat_pkg::*;
#(
    parameter int N_LINKS    = 4,
    parameter int CNT_W      = 16,
    parameter int ID_W       = 4,
    parameter int TAG_W      = 6,
    parameter int BC_W       = 4,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int CFG_WORDS  = 4,
    parameter int CFG_STRIDE = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ID_W-1:0]             my_id,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_op,
    input  logic [ID_W-1:0]             req_dest,
    input  logic [N_LINKS-1:0]          req_mask,
    input  logic [BC_W-1:0]             req_bcast,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [N_LINKS-1:0]          flit_pulse,
    output logic                        rsp_valid,
    output logic [TAG_W-1:0]            rsp_tag,
    output logic                        rsp_err,
    output logic [CNT_W-1:0]            rsp_count,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_rsp_valid,
    input  logic [DATA_W-1:0]           mem_rsp_data,
    output logic [CFG_WORDS*DATA_W-1:0] cfg_out
);

    localparam int SEL_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;

    logic                            busy;
    logic                            accept;
    stat_act_t                       act;
    logic                            sel_ok;
    logic [SEL_W-1:0]                sel_idx;
    logic [N_LINKS-1:0][CNT_W-1:0]   cnt_q;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    link_stat_decode #(
        .N_LINKS (N_LINKS),
        .ID_W    (ID_W),
        .BC_W    (BC_W)
    ) i_decode (
        .accept  (accept),
        .op      (req_op),
        .dest    (req_dest),
        .my_id   (my_id),
        .bcast   (req_bcast),
        .mask    (req_mask),
        .act     (act),
        .sel_ok  (sel_ok),
        .sel_idx (sel_idx)
    );

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        link_stat_counter #(
            .CNT_W (CNT_W)
        ) i_counter (
            .clk   (clk),
            .rst   (rst),
            .bump  (flit_pulse[g]),
            .clear (act.clr && req_mask[g]),
            .count (cnt_q[g])
        );
    end

    link_stat_cfg_fetch #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CFG_WORDS  (CFG_WORDS),
        .CFG_STRIDE (CFG_STRIDE),
        .ID_W       (ID_W)
    ) i_fetch (
        .clk           (clk),
        .rst           (rst),
        .start         (act.cfg),
        .base          (req_addr),
        .my_id         (my_id),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .cfg_out       (cfg_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
            rsp_err   <= 1'b0;
            rsp_count <= '0;
        end else begin
            rsp_valid <= act.rd;
            if (act.rd) begin
                rsp_tag   <= req_tag;
                rsp_err   <= !sel_ok;
                rsp_count <= sel_ok ? cnt_q[sel_idx] : '0;
            end
        end
    end

endmodule

// File: rtl/link_stat_chk.sv
module link_stat_chk
    import link_stat_pkg::*;
#(
    parameter int N_LINKS   = 4,
    parameter int CNT_W     = 16,
    parameter int ID_W      = 4,
    parameter int TAG_W     = 6,
    parameter int BC_W      = 4,
    parameter int DATA_W    = 32,
    parameter int CFG_WORDS = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ID_W-1:0]               my_id,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [1:0]                    req_op,
    input logic [ID_W-1:0]               req_dest,
    input logic [N_LINKS-1:0]            req_mask,
    input logic [BC_W-1:0]               req_bcast,
    input logic [TAG_W-1:0]              req_tag,
    input logic [N_LINKS-1:0]            flit_pulse,
    input logic                          rsp_valid,
    input logic [TAG_W-1:0]              rsp_tag,
    input logic                          rsp_err,
    input logic [CNT_W-1:0]              rsp_count,
    input logic                          mem_req,
    input logic                          mem_rsp_valid,
    input logic [CFG_WORDS*DATA_W-1:0]   cfg_out,
    input logic [N_LINKS-1:0][CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                rd_hit;
    logic [N_LINKS-1:0]  clr_hit;

    assign rd_hit = req_valid && req_ready && (req_op == OP_READ) && (req_dest == my_id);

    always_comb begin
        for (int i = 0; i < N_LINKS; i++) begin
            clr_hit[i] = req_valid && req_ready && (req_op == OP_CLEAR) &&
                         ((req_bcast != '0) || (req_dest == my_id)) && req_mask[i];
        end
    end

    // R3
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> (rsp_valid && (rsp_tag == $past(req_tag))));

    // R7
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> !rsp_valid);

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_count == '0));

    // R10
    mem_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_rsp_valid |=> $stable(cfg_out));

    for (genvar g = 0; g < N_LINKS; g++) begin : g_cnt
        // R6
        clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
            clr_hit[g] |=> (cnt_q[g] == '0));

        // R2
        saturate_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr_hit[g] && (cnt_q[g] == CNT_MAX)) |=> (cnt_q[g] == CNT_MAX));

        // R1
        step_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr_hit[g] && flit_pulse[g] && (cnt_q[g] != CNT_MAX))
                |=> (cnt_q[g] == CNT_W'($past(cnt_q[g]) + CNT_W'(1))));
    end

endmodule

bind link_stat_agent link_stat_chk #(
    .N_LINKS   (N_LINKS),
    .CNT_W     (CNT_W),
    .ID_W      (ID_W),
    .TAG_W     (TAG_W),
    .BC_W      (BC_W),
    .DATA_W    (DATA_W),
    .CFG_WORDS (CFG_WORDS)
) i_link_stat_chk (.*);

// File: tb/test_link_stat_agent.sv
module test_link_stat_agent;

    localparam int N      = 4;
    localparam int CW     = 6;
    localparam int IDW    = 4;
    localparam int TW     = 6;
    localparam int BW     = 4;
    localparam int AW     = 16;
    localparam int DW     = 32;
    localparam int CWORDS = 4;
    localparam int STR    = 16;
    localparam logic [IDW-1:0] MY_ID   = 4'd5;
    localparam logic [CW-1:0]  CNT_MAX = '1;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic [1:0]             req_op = '0;
    logic [IDW-1:0]         req_dest = '0;
    logic [N-1:0]           req_mask = '0;
    logic [BW-1:0]          req_bcast = '0;
    logic [TW-1:0]          req_tag = '0;
    logic [AW-1:0]          req_addr = '0;
    logic [N-1:0]           flit_pulse = '0;
    logic                   rsp_valid;
    logic [TW-1:0]          rsp_tag;
    logic                   rsp_err;
    logic [CW-1:0]          rsp_count;
    logic                   mem_req;
    logic [AW-1:0]          mem_addr;
    logic                   mem_rsp_valid = 1'b0;
    logic [DW-1:0]          mem_rsp_data = '0;
    logic [CWORDS*DW-1:0]   cfg_out;

    always #2 clk = ~clk;

    link_stat_agent #(
        .N_LINKS (N), .CNT_W (CW), .ID_W (IDW), .TAG_W (TW), .BC_W (BW),
        .ADDR_W (AW), .DATA_W (DW), .CFG_WORDS (CWORDS), .CFG_STRIDE (STR)
    ) i_link_stat_agent (
        .clk (clk), .rst (rst), .my_id (MY_ID),
        .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
        .req_dest (req_dest), .req_mask (req_mask), .req_bcast (req_bcast),
        .req_tag (req_tag), .req_addr (req_addr), .flit_pulse (flit_pulse),
        .rsp_valid (rsp_valid), .rsp_tag (rsp_tag), .rsp_err (rsp_err),
        .rsp_count (rsp_count), .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
        .cfg_out (cfg_out)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    started = 0;
    string phase_tag = "";
    logic [TW-1:0] tag_ctr = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'hA5C3_1E0F;
    endfunction

    // Reference model state
    logic [CW-1:0]        m_cnt [N];
    bit                   m_busy;
    int                   m_words;
    logic [AW-1:0]        m_origin;
    logic [DW-1:0]        m_shadow [CWORDS];
    logic [CWORDS*DW-1:0] m_cfg;
    bit                   e_rv;
    logic [TW-1:0]        e_tag;
    bit                   e_err;
    logic [CW-1:0]        e_cnt;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) m_cnt[i] = '0;
            m_busy = 0; m_words = 0; m_origin = '0; m_cfg = '0;
            e_rv = 0; e_tag = '0; e_err = 0; e_cnt = '0;
        end else begin
            bit acc;
            bit tgt;
            acc = req_valid && !m_busy;
            tgt = (req_bcast != '0) || (req_dest == MY_ID);
            e_rv = 0;
            if (acc && req_op == 2'b01 && req_dest == MY_ID) begin
                e_rv  = 1;
                e_tag = req_tag;
                e_err = ($countones(req_mask) != 1);
                e_cnt = '0;
                if (!e_err)
                    for (int i = 0; i < N; i++) if (req_mask[i]) e_cnt = m_cnt[i];
            end
            for (int i = 0; i < N; i++) begin
                if (acc && req_op == 2'b10 && tgt && req_mask[i]) m_cnt[i] = '0;
                else if (flit_pulse[i] && m_cnt[i] != CNT_MAX) m_cnt[i] = m_cnt[i] + 1'b1;
            end
            if (m_busy && mem_rsp_valid) begin
                m_shadow[m_words] = mem_rsp_data;
                m_words++;
                if (m_words == CWORDS) begin
                    for (int k = 0; k < CWORDS; k++) m_cfg[k*DW +: DW] = m_shadow[k];
                    m_busy = 0;
                end
            end
            if (acc && req_op == 2'b11 && tgt) begin
                m_busy   = 1;
                m_words  = 0;
                m_origin = req_addr + AW'(MY_ID) * AW'(STR);
            end
        end
    end

    // Memory responder: answers one to three falling edges after a request
    bit            mem_pend = 0;
    int            mem_delay = 0;
    logic [AW-1:0] mem_pend_addr = '0;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mem_pend) begin
            if (mem_delay == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(mem_pend_addr);
                mem_pend      = 0;
            end else begin
                mem_delay--;
            end
        end
        if (!rst && mem_req) begin
            mem_pend      = 1;
            mem_delay     = $urandom % 3;
            mem_pend_addr = mem_addr;
        end
    end

    // Output comparison, one register stage after the model's edge
    always @(negedge clk) begin
        if (!rst && started) begin
            string lab;
            lab = (phase_tag == "") ? "R3" : phase_tag;
            check(rsp_valid == e_rv, lab, "rsp_valid", 128'(rsp_valid), 128'(e_rv));
            if (e_rv && rsp_valid) begin
                check(rsp_tag == e_tag, lab, "rsp_tag", 128'(rsp_tag), 128'(e_tag));
                check(rsp_err == e_err, e_err ? "R4" : lab, "rsp_err", 128'(rsp_err), 128'(e_err));
                check(rsp_count == e_cnt, e_err ? "R4" : ((e_cnt == CNT_MAX) ? "R2" : lab),
                      "rsp_count", 128'(rsp_count), 128'(e_cnt));
            end
            check(req_ready == !m_busy, "R10", "req_ready", 128'(req_ready), 128'(!m_busy));
            check(cfg_out == m_cfg, "R9", "cfg_out", 128'(cfg_out), 128'(m_cfg));
            if (mem_req)
                check(mem_addr == m_origin + AW'(m_words), "R8", "mem_addr",
                      128'(mem_addr), 128'(m_origin + AW'(m_words)));
        end
    end

    task automatic step(input bit v, input logic [1:0] op, input logic [IDW-1:0] d,
                        input logic [N-1:0] m, input logic [BW-1:0] b,
                        input logic [AW-1:0] a, input logic [N-1:0] p);
        @(negedge clk);
        req_valid  = v;
        req_op     = op;
        req_dest   = d;
        req_mask   = m;
        req_bcast  = b;
        req_addr   = a;
        req_tag    = tag_ctr;
        tag_ctr    = tag_ctr + 1'b1;
        flit_pulse = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'b00, '0, '0, '0, '0, '0);
    endtask

    task automatic read_all();
        for (int i = 0; i < N; i++) step(1, 2'b01, MY_ID, N'(1) << i, '0, '0, '0);
        idle(1);
    endtask

    task automatic wait_ready();
        idle(1);
        while (!req_ready) idle(1);
        idle(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h1F2E));
        repeat (4) @(negedge clk);
        // R11: outputs during and right after reset
        check(rsp_valid == 1'b0, "R11", "rsp_valid", 128'(rsp_valid), 0);
        check(req_ready == 1'b1, "R11", "req_ready", 128'(req_ready), 1);
        check(mem_req == 1'b0, "R11", "mem_req", 128'(mem_req), 0);
        check(cfg_out == '0, "R11", "cfg_out", 128'(cfg_out), 0);
        rst = 1'b0;
        started = 1;
        phase_tag = "R11";
        read_all();

        phase_tag = "R1";
        for (int i = 0; i < 5; i++) step(0, 2'b00, '0, '0, '0, '0, 4'b0101);
        step(0, 2'b00, '0, '0, '0, '0, 4'b1000);
        read_all();

        phase_tag = "R2";
        for (int i = 0; i < 70; i++) step(0, 2'b00, '0, '0, '0, '0, 4'b1111);
        read_all();

        phase_tag = "R6";
        step(1, 2'b10, MY_ID, 4'b1111, '0, '0, 4'b1111);
        read_all();

        phase_tag = "R5";
        for (int i = 0; i < 3; i++) step(0, 2'b00, '0, '0, '0, '0, 4'b1111);
        step(1, 2'b10, 4'd9, 4'b0110, 4'd1, '0, '0);
        read_all();

        phase_tag = "R7";
        step(1, 2'b10, 4'd9, 4'b1111, '0, '0, '0);
        step(1, 2'b01, 4'd9, 4'b0001, '0, '0, '0);
        step(1, 2'b01, 4'd2, 4'b1000, 4'd3, '0, '0);
        step(1, 2'b00, MY_ID, 4'b1111, 4'd1, '0, '0);
        read_all();

        phase_tag = "R4";
        step(1, 2'b01, MY_ID, 4'b0000, '0, '0, '0);
        step(1, 2'b01, MY_ID, 4'b1010, '0, '0, '0);
        step(1, 2'b01, MY_ID, 4'b1111, '0, '0, '0);
        idle(1);

        phase_tag = "R10";
        step(1, 2'b11, MY_ID, '0, '0, 16'h0100, 4'b0011);
        step(1, 2'b10, MY_ID, 4'b1111, 4'd1, '0, 4'b0011);
        step(1, 2'b01, MY_ID, 4'b0001, '0, '0, 4'b0011);
        wait_ready();
        read_all();
        step(1, 2'b11, 4'd9, '0, 4'd2, 16'h2000, '0);
        wait_ready();
        step(1, 2'b11, 4'd9, '0, '0, 16'h3000, '0);
        idle(3);

        phase_tag = "";
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] op;
            op = 2'($urandom % 4);
            if (op == 2'b11 && ($urandom % 4) != 0) op = 2'b01;
            step(($urandom % 2) == 0, op,
                 (($urandom % 2) == 0) ? MY_ID : IDW'($urandom),
                 (($urandom % 3) == 0) ? N'($urandom) : (N'(1) << ($urandom % N)),
                 (($urandom % 4) == 0) ? BW'($urandom) : '0,
                 AW'($urandom), N'($urandom));
        end
        wait_ready();
        read_all();
        idle(4);
        finish_run();
    end

endmodule